// File: doc/BRIEF.md
# Pipelined Shift-Add Dual Constant Multiplier

This block multiplies a stream of signed samples by two fixed constants, 45 and 47, without any multiplier hardware. Each product is built from a small graph of add/subtract nodes whose operands are shifted by hardwired wiring. Every node registers its result, so the logic between any two flops is one adder deep.

The 45 product is a cascade of two registered nodes: 5X is formed first, then 45X from it. The 47 product has two possible structures, chosen by a parameter. With two-operand nodes it uses the signed-digit form 64X − 16X − X, built in two registered subtractions. With a three-operand node it collapses into one registered stage. In that case a pure delay register pads the path so that both products leave on the same cycle.

A valid bit moves through a register chain as deep as the data path. The consumer therefore sees both products and their qualifier aligned, two cycles after the sample entered.

Top module: `shadd_cmul`

## Requirements
- R1: `p45` equals 45 times the `in_data` sample presented two rising clock edges earlier, as a signed two's-complement value of W+7 bits.
- R2: `p47` equals 47 times the `in_data` sample presented two rising clock edges earlier, as a signed two's-complement value of W+7 bits.
- R3: Both products come from the same input sample on every cycle. Seen at the ports, 47·`p45` equals 45·`p47` whenever `out_valid` is high.
- R4: `out_valid` equals the `in_valid` value presented two rising edges earlier.
- R5: A synchronous active-high `rst` drives `out_valid` low and both products to zero at the edge where it is sampled high. This holds even while `in_valid` is high.
- R6: The most negative input (−2^(W−1)) and the most positive input (2^(W−1)−1) produce exact products with no wrap-around.
- R7: The three-operand setting (`TRI_ADD` = 1) gives results and latency identical to the two-operand setting (`TRI_ADD` = 0) for every input.
- R8: The data path advances on every clock regardless of `in_valid`. A sample presented with `in_valid` low still appears as its products two edges later, with `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifier for `in_data` |
| in_data | input | W | Signed input sample |
| out_valid | output | 1 | Qualifier for the products, two cycles behind `in_valid` |
| p45 | output | W+7 | Signed product 45·X |
| p47 | output | W+7 | Signed product 47·X |

## Verification
The bench builds two copies with W = 8: one with `TRI_ADD` = 0 and one with `TRI_ADD` = 1. Both copies see the same stimulus, so every check covers both graph variants. An 8-bit input lets a streaming sweep cover all 256 input codes, which includes both extreme values. On top of that sweep, the bench runs alternating and random valid patterns, plus a reset asserted in the middle of a stream.

// File: rtl/shadd_pkg.sv
package shadd_pkg;

    // Operand sign selection for an add node
    typedef enum logic {
        SG_ADD = 1'b0,
        SG_SUB = 1'b1
    } sign_e;

    // Guard bits added above the input width: 47 < 2^6, plus sign headroom
    localparam int EXT_BITS = 7;

    // Stages from input to output for every product
    localparam int PIPE_LAT = 2;

    // Constants realised by the graphs
    localparam int K_LO = 45;
    localparam int K_HI = 47;

    function automatic int out_width(input int w);
        return w + EXT_BITS;
    endfunction

endpackage

// File: rtl/shadd_node.sv
module shadd_node #(
    parameter int              W    = 23,
    parameter int              NIN  = 2,
    parameter int              L0   = 0,
    parameter int              L1   = 0,
    parameter int              L2   = 0,
    parameter shadd_pkg::sign_e S1  = shadd_pkg::SG_ADD,
    parameter shadd_pkg::sign_e S2  = shadd_pkg::SG_ADD,
    parameter int              RSH  = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] a0,
    input  logic signed [W-1:0] a1,
    input  logic signed [W-1:0] a2,
    output logic signed [W-1:0] y
);
    import shadd_pkg::*;

    logic signed [W-1:0] t0, t1, t2, sum;

    // Operand terms: hardwired left shifts, fixed signs
    always_comb begin
        t0 = a0 <<< L0;
        t1 = (S1 == SG_SUB) ? -(a1 <<< L1) : (a1 <<< L1);
        if (NIN == 3) begin
            t2 = (S2 == SG_SUB) ? -(a2 <<< L2) : (a2 <<< L2);
        end else begin
            t2 = '0;
        end
        sum = t0 + t1 + t2;
    end

    // Registered result with optional arithmetic right shift
    always_ff @(posedge clk) begin
        if (rst) begin
            y <= '0;
        end else begin
            y <= sum >>> RSH;
        end
    end

endmodule

// File: rtl/shadd_delay.sv
module shadd_delay #(
    parameter int W     = 23,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] stg [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
                end
            end
            assign q = stg[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/shadd_cmul.sv
module shadd_cmul #(
    parameter int W       = 16,
    parameter bit TRI_ADD = 1'b0,
    localparam int OW     = shadd_pkg::out_width(W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [W-1:0]  in_data,
    output logic                 out_valid,
    output logic signed [OW-1:0] p45,
    output logic signed [OW-1:0] p47
);
    import shadd_pkg::*;

    localparam int EXT = OW - W;

    logic signed [OW-1:0] xs;
    logic signed [OW-1:0] f5;

    assign xs = {{EXT{in_data[W-1]}}, in_data};

    // 45X: stage 1 forms 5X = 4X + X, stage 2 forms 45X = 40X + 5X
    shadd_node #(.W(OW), .NIN(2), .L0(2), .L1(0)) u_n5 (
        .clk(clk), .rst(rst), .a0(xs), .a1(xs), .a2('0), .y(f5)
    );
    shadd_node #(.W(OW), .NIN(2), .L0(3), .L1(0)) u_n45 (
        .clk(clk), .rst(rst), .a0(f5), .a1(f5), .a2('0), .y(p45)
    );

    // 47X: structure picked by TRI_ADD
    generate
        if (TRI_ADD) begin : g_tri
            logic signed [OW-1:0] f47;
            // One stage: 64X - 16X - X
            shadd_node #(.W(OW), .NIN(3), .L0(6), .L1(4), .L2(0),
                         .S1(SG_SUB), .S2(SG_SUB)) u_n47 (
                .clk(clk), .rst(rst), .a0(xs), .a1(xs), .a2(xs), .y(f47)
            );
            // Balance to the depth of the 45X path
            shadd_delay #(.W(OW), .DEPTH(PIPE_LAT - 1)) u_bal (
                .clk(clk), .rst(rst), .d(f47), .q(p47)
            );
        end else begin : g_duo
            logic signed [OW-1:0] f63;
            logic signed [OW-1:0] xd;
            // Stage 1: 63X = 64X - X, with X carried by a pure register
            shadd_node #(.W(OW), .NIN(2), .L0(6), .L1(0), .S1(SG_SUB)) u_n63 (
                .clk(clk), .rst(rst), .a0(xs), .a1(xs), .a2('0), .y(f63)
            );
            shadd_delay #(.W(OW), .DEPTH(1)) u_xd (
                .clk(clk), .rst(rst), .d(xs), .q(xd)
            );
            // Stage 2: 47X = 63X - 16X
            shadd_node #(.W(OW), .NIN(2), .L0(0), .L1(4), .S1(SG_SUB)) u_n47 (
                .clk(clk), .rst(rst), .a0(f63), .a1(xd), .a2('0), .y(p47)
            );
        end
    endgenerate

    // Qualifier travels the same number of stages
    shadd_delay #(.W(1), .DEPTH(PIPE_LAT)) u_vld (
        .clk(clk), .rst(rst), .d(in_valid), .q(out_valid)
    );

endmodule

// File: rtl/shadd_cmul_chk.sv
module shadd_cmul_chk #(
    parameter int W  = 16,
    parameter int OW = W + 7
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic signed [W-1:0]  in_data,
    input logic                 out_valid,
    input logic signed [OW-1:0] p45,
    input logic signed [OW-1:0] p47
);
    logic [1:0]          cnt;
    logic signed [W-1:0] d1, d2;
    logic                v1, v2;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt != 2'd2) begin
            cnt <= cnt + 2'd1;
        end
        d1 <= in_data;
        d2 <= d1;
        v1 <= in_valid;
        v2 <= v1;
    end

    // R1
    p45_value_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == 2'd2) |-> (int'(p45) == 45 * int'(d2)));

    // R2
    p47_value_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == 2'd2) |-> (int'(p47) == 47 * int'(d2)));

    // R3
    pair_align_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (47 * int'(p45) == 45 * int'(p47)));

    // R4
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == 2'd2) |-> (out_valid == v2));

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && p45 == '0 && p47 == '0));

endmodule

bind shadd_cmul shadd_cmul_chk #(.W(W), .OW(OW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .p45(p45), .p47(p47)
);

// File: tb/shadd_cmul_bench.sv
module shadd_cmul_bench;
    localparam int W  = 8;
    localparam int OW = W + 7;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [W-1:0]  in_data = '0;
    logic                 ov_a, ov_b;
    logic signed [OW-1:0] p45_a, p47_a, p45_b, p47_b;

    int n_chk = 0;
    int n_bad = 0;
    int primed = 0;
    logic signed [W-1:0] h1d = '0, h2d = '0;
    logic                h1v = 1'b0, h2v = 1'b0;

    always #10 clk = ~clk;

    shadd_cmul #(.W(W), .TRI_ADD(1'b0)) u_shadd_cmul (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov_a), .p45(p45_a), .p47(p47_a)
    );
    shadd_cmul #(.W(W), .TRI_ADD(1'b1)) u_shadd_cmul_tri (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov_b), .p45(p45_b), .p47(p47_b)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp(input int act, input int exp, input string tag);
        chk(act == exp, tag, act, exp);
    endtask

    // One streaming cycle: check what is due, then drive the next sample
    task automatic step(input logic signed [W-1:0] d, input logic v, input string sc);
        @(negedge clk);
        if (primed >= 2) begin
            int x = int'(h2d);
            cmp(int'(p45_a), 45 * x, {"R1 ", sc});
            cmp(int'(p47_a), 47 * x, {"R2 ", sc});
            cmp(int'(ov_a), int'(h2v), {"R4 R8 ", sc});
            cmp(47 * int'(p45_a), 45 * int'(p47_a), {"R3 ", sc});
            cmp(int'(p45_b), 45 * x, {"R7 p45 ", sc});
            cmp(int'(p47_b), 47 * x, {"R7 p47 ", sc});
            cmp(int'(ov_b), int'(h2v), {"R7 valid ", sc});
        end
        h2d = h1d; h2v = h1v;
        h1d = d;   h1v = v;
        in_data = d; in_valid = v;
        if (primed < 2) primed++;
    endtask

    task automatic flush(input string sc);
        step('0, 1'b0, sc);
        step('0, 1'b0, sc);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; in_data = 8'sd100;
        repeat (3) @(negedge clk);
        cmp(int'(ov_a), 0, "R5 reset valid");
        cmp(int'(p45_a), 0, "R5 reset p45");
        cmp(int'(p47_a), 0, "R5 reset p47");
        cmp(int'(ov_b), 0, "R5 reset valid tri");
        cmp(int'(p47_b), 0, "R5 reset p47 tri");
        rst = 1'b0; in_valid = 1'b0; in_data = '0;
        primed = 0;
    endtask

    task automatic t_corners();
        step(-8'sd128, 1'b1, "R6 min");
        step( 8'sd127, 1'b1, "R6 max");
        step( 8'sd0,   1'b1, "R6 zero");
        step( 8'sd1,   1'b1, "R6 one");
        step(-8'sd1,   1'b1, "R6 neg one");
        step(-8'sd128, 1'b1, "R6 min again");
        flush("R6 flush");
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 256; i++) step(W'(i), 1'b1, "sweep");
        flush("sweep flush");
    endtask

    task automatic t_valid_mix();
        for (int i = 0; i < 40; i++) step(W'(i * 37 + 5), i[0], "R8 alternating");
        for (int i = 0; i < 20; i++) step(W'(-i * 11), 1'b0, "R8 idle data");
        flush("R8 flush");
    endtask

    task automatic t_random();
        for (int i = 0; i < 500; i++) step(W'($urandom), 1'($urandom), "random");
        flush("random flush");
    endtask

    task automatic t_midreset();
        for (int i = 0; i < 5; i++) step(W'(i * 29 - 70), 1'b1, "pre-reset");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        cmp(int'(ov_a), 0, "R5 mid-stream valid");
        cmp(int'(p45_a), 0, "R5 mid-stream p45");
        cmp(int'(p47_b), 0, "R5 mid-stream p47 tri");
        rst = 1'b0; in_valid = 1'b0; in_data = '0;
        primed = 0;
        for (int i = 0; i < 6; i++) step(W'(i * 13 + 1), 1'b1, "post-reset");
        flush("post-reset flush");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_corners();
        t_sweep();
        t_valid_mix();
        t_random();
        t_midreset();
        t_reset();
        t_corners();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule